// File: doc/BRIEF.md
# Counting Packet Stream Source

This block is a test-pattern source for a stream-to-memory DMA engine. It drives a 32-bit AXI4-Stream master whose payload is a free-running count. The count restarts at zero for each run and steps by one for every beat the receiver accepts. The stream is cut into packets of a programmed length. TLAST marks the final beat of every packet, so each packet boundary lines up with the transfer length that software sets on the DMA side.

Software programs two lengths, each written as the desired count minus one: words per packet and packets per run. It then produces a rising edge on the start input. A busy output stays high from the start edge until the last beat of the last packet has been accepted. A clear input aborts any run at once and returns the block to idle.

Top module: `pkt_pattern_gen`

## Requirements
- R1: After `rst_n` goes low, or after a cycle with `swClear` high, `busy` and `mTvalid` are 0.
- R2: While idle, a rising edge on `startReq` (1 this cycle, 0 the cycle before) makes `busy` and `mTvalid` high from the next clock edge, with `mTdata` equal to 0.
- R3: A beat is transferred only on a clock edge where `mTvalid` and `mTready` are both 1. While `mTvalid` is 1 and `mTready` is 0, `mTdata` and `mTlast` hold their values.
- R4: Within a packet, beats are numbered 0 to `beatsMinusOne`. `mTlast` is 1 only on beat `beatsMinusOne`, once per packet, and never earlier.
- R5: `mTdata` equals the number of beats accepted since the run started. It keeps counting across packet boundaries.
- R6: A run carries `packetsMinusOne`+1 packets. After the last beat of the final packet is accepted, `busy` and `mTvalid` are 0 from the next edge.
- R7: Changes to `beatsMinusOne` and `packetsMinusOne`, and any rising edge on `startReq`, during a run have no effect on the run. The lengths are captured on the start edge.
- R8: `swClear` during a run stops it. From the next edge `busy` and `mTvalid` are 0, and the next run starts again at data 0. `swClear` takes priority over a beat accepted in the same cycle.
- R9: Holding `startReq` at 1 past the end of a run does not begin a new run. Only a new rising edge does.
- R10: With `beatsMinusOne` = 0, every beat carries `mTlast` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| swClear | input | 1 | Software abort and clear, synchronous, active high |
| startReq | input | 1 | Start control; a rising edge begins a run |
| beatsMinusOne | input | CNT_W | Words per packet minus one |
| packetsMinusOne | input | CNT_W | Packets per run minus one |
| busy | output | 1 | High while a run is in progress |
| mTdata | output | DATA_W | Stream payload (beat counter) |
| mTvalid | output | 1 | Stream valid |
| mTlast | output | 1 | Last beat of a packet |
| mTready | input | 1 | Stream ready from the receiver |

## Verification
Two functions can fall in the same cycle: a beat being accepted, and an abort from `swClear` (or a start edge arriving while a beat is in flight). The bench provokes the abort with `mTready` held high, so the clear and an accepted beat meet on one edge. It then requires idle outputs on the following edge and a fresh run that begins at data 0. The same-cycle start case is provoked by raising `startReq` in the middle of a run that uses irregular ready patterns. It is judged by the beat-by-beat data and TLAST model staying on the originally captured lengths.

// File: rtl/pktgen_pkg.sv
package pktgen_pkg;
  typedef struct packed {
    logic runLoad;   // capture lengths, zero counters
    logic beatAdv;   // one beat accepted
    logic clearAll;  // abort and clear
  } ctrl_strobes_t;
endpackage

// File: rtl/pktgen_ctrl.sv
module pktgen_ctrl
  import pktgen_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          swClear,
  input  logic          startReq,
  input  logic          mTready,
  input  logic          finalBeat,
  output logic          busy,
  output ctrl_strobes_t strobes
);
  logic startPrev;
  logic startRise;
  logic beatFire;

  assign startRise = startReq & ~startPrev;
  assign beatFire  = busy & mTready;

  always_comb begin
    strobes.clearAll = swClear;
    strobes.runLoad  = ~swClear & ~busy & startRise;
    strobes.beatAdv  = ~swClear & beatFire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      startPrev <= 1'b0;
      busy      <= 1'b0;
    end else begin
      startPrev <= startReq;
      if (swClear)
        busy <= 1'b0;
      else if (!busy && startRise)
        busy <= 1'b1;
      else if (beatFire && finalBeat)
        busy <= 1'b0;
    end
  end

  assert_clear_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    swClear |=> !busy);

  assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !swClear && !(mTready && finalBeat)) |=> busy);

endmodule

// File: rtl/pktgen_datapath.sv
module pktgen_datapath
  import pktgen_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
)(
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_strobes_t     strobes,
  input  logic [CNT_W-1:0]  beatsMinusOne,
  input  logic [CNT_W-1:0]  packetsMinusOne,
  output logic [DATA_W-1:0] mTdata,
  output logic              mTlast,
  output logic              finalBeat
);
  logic [CNT_W-1:0]  beatLenQ;
  logic [CNT_W-1:0]  pktLenQ;
  logic [CNT_W-1:0]  beatCnt;
  logic [CNT_W-1:0]  pktCnt;
  logic [DATA_W-1:0] dataCnt;
  logic              beatWrap;

  assign beatWrap  = (beatCnt == beatLenQ);
  assign mTlast    = beatWrap;
  assign finalBeat = beatWrap && (pktCnt == pktLenQ);
  assign mTdata    = dataCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beatLenQ <= '0;
      pktLenQ  <= '0;
      beatCnt  <= '0;
      pktCnt   <= '0;
      dataCnt  <= '0;
    end else if (strobes.clearAll) begin
      beatLenQ <= '0;
      pktLenQ  <= '0;
      beatCnt  <= '0;
      pktCnt   <= '0;
      dataCnt  <= '0;
    end else if (strobes.runLoad) begin
      beatLenQ <= beatsMinusOne;
      pktLenQ  <= packetsMinusOne;
      beatCnt  <= '0;
      pktCnt   <= '0;
      dataCnt  <= '0;
    end else if (strobes.beatAdv) begin
      dataCnt <= dataCnt + 1'b1;
      if (beatWrap) begin
        beatCnt <= '0;
        pktCnt  <= pktCnt + 1'b1;
      end else begin
        beatCnt <= beatCnt + 1'b1;
      end
    end
  end

  assert_data_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.beatAdv && !strobes.clearAll) |=> mTdata == $past(mTdata) + 1'b1);

  assert_tlast_rollover_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.beatAdv && !strobes.clearAll && mTlast && !finalBeat)
      |=> (beatCnt == '0) && (pktCnt == $past(pktCnt) + 1'b1));

endmodule

// File: rtl/pkt_pattern_gen.sv
module pkt_pattern_gen
  import pktgen_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              swClear,
  input  logic              startReq,
  input  logic [CNT_W-1:0]  beatsMinusOne,
  input  logic [CNT_W-1:0]  packetsMinusOne,
  output logic              busy,
  output logic [DATA_W-1:0] mTdata,
  output logic              mTvalid,
  output logic              mTlast,
  input  logic              mTready
);
  ctrl_strobes_t strobes;
  logic          finalBeat;

  pktgen_ctrl ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .swClear   (swClear),
    .startReq  (startReq),
    .mTready   (mTready),
    .finalBeat (finalBeat),
    .busy      (busy),
    .strobes   (strobes)
  );

  pktgen_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) dp_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .strobes         (strobes),
    .beatsMinusOne   (beatsMinusOne),
    .packetsMinusOne (packetsMinusOne),
    .mTdata          (mTdata),
    .mTlast          (mTlast),
    .finalBeat       (finalBeat)
  );

  assign mTvalid = busy;

  assert_hold_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mTvalid && !mTready && !swClear)
      |=> mTvalid && $stable(mTdata) && $stable(mTlast));

endmodule

// File: tb/pkt_pattern_gen_tb_top.sv
module pkt_pattern_gen_tb_top;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              swClear = 1'b0;
  logic              startReq = 1'b0;
  logic [CNT_W-1:0]  beatsMinusOne = '0;
  logic [CNT_W-1:0]  packetsMinusOne = '0;
  logic              busy;
  logic [DATA_W-1:0] mTdata;
  logic              mTvalid;
  logic              mTlast;
  logic              mTready = 1'b0;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pkt_pattern_gen #(.DATA_W(DATA_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .swClear(swClear), .startReq(startReq),
    .beatsMinusOne(beatsMinusOne), .packetsMinusOne(packetsMinusOne),
    .busy(busy), .mTdata(mTdata), .mTvalid(mTvalid), .mTlast(mTlast),
    .mTready(mTready)
  );

  typedef struct packed {
    logic [7:0] beatsM1;
    logic [7:0] pktsM1;
    logic [7:0] readyMask;
  } vec_t;

  localparam int NVEC = 5;
  localparam vec_t VECS [NVEC] = '{
    '{8'd3, 8'd1, 8'hFF},
    '{8'd0, 8'd2, 8'hAA},
    '{8'd4, 8'd0, 8'hB3},
    '{8'd2, 8'd3, 8'h6D},
    '{8'd1, 8'd1, 8'h81}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      finish_run();
    end
  end

  // Start a run and walk it beat by beat against a model.
  task automatic run_vector(input vec_t v);
    int expData = 0;
    int expBeat = 0;
    int expPkt  = 0;
    int cyc     = 0;
    bit running = 1'b1;
    @(negedge clk);
    beatsMinusOne   = CNT_W'(v.beatsM1);
    packetsMinusOne = CNT_W'(v.pktsM1);
    startReq = 1'b1;
    mTready  = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R2 busy after start", busy, 1);
    check("R2 first data", mTdata, 0);
    startReq = 1'b0;
    beatsMinusOne   = 16'h00FF;   // R7: must not change the running packet length
    packetsMinusOne = 16'h00FF;
    while (running) begin
      check("R6 busy during run", busy, 1);
      check("R3 valid", mTvalid, 1);
      check("R5 data", mTdata, expData);
      check("R4 tlast", mTlast, (expBeat == int'(v.beatsM1)) ? 1 : 0);
      startReq = (cyc == 2);     // R7: start edge mid-run is ignored
      mTready  = v.readyMask[cyc % 8];
      if (mTready) begin
        expData++;
        if (expBeat == int'(v.beatsM1)) begin
          expBeat = 0;
          if (expPkt == int'(v.pktsM1)) running = 1'b0;
          expPkt++;
        end else expBeat++;
      end
      cyc++;
      @(posedge clk);
      @(negedge clk);
    end
    startReq = 1'b0;
    mTready  = 1'b0;
    check("R6 busy low after last", busy, 0);
    check("R6 valid low after last", mTvalid, 0);
    check("R6 packet count", expPkt, int'(v.pktsM1) + 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 busy in reset", busy, 0);
    check("R1 valid in reset", mTvalid, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) run_vector(VECS[i]);

    // R8: abort while a beat is being accepted
    @(negedge clk);
    beatsMinusOne = 16'd3; packetsMinusOne = 16'd3;
    startReq = 1'b1; mTready = 1'b1;
    @(posedge clk); @(negedge clk);
    startReq = 1'b0;
    repeat (5) @(negedge clk);
    check("R8 mid-run data before clear", mTdata, 5);
    swClear = 1'b1;
    @(posedge clk); @(negedge clk);
    swClear = 1'b0;
    check("R8 busy after clear", busy, 0);
    check("R8 valid after clear", mTvalid, 0);
    check("R1 clear idles valid", mTvalid, 0);
    @(negedge clk);
    check("R8 stays idle", busy, 0);

    // R10 and R8 restart: single-beat packets start again at zero
    beatsMinusOne = 16'd0; packetsMinusOne = 16'd1;
    startReq = 1'b1; mTready = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R8 restart data", mTdata, 0);
    check("R10 tlast beat0", mTlast, 1);
    mTready = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R10 tlast beat1", mTlast, 1);
    check("R5 data beat1", mTdata, 1);
    @(posedge clk); @(negedge clk);
    check("R6 done after 2 packets", busy, 0);

    // R9: startReq still held high, no new run
    repeat (3) @(negedge clk);
    check("R9 held start no restart busy", busy, 0);
    check("R9 held start no restart valid", mTvalid, 0);
    startReq = 1'b0; mTready = 1'b0;
    @(negedge clk);

    // R1: asynchronous reset mid-run
    startReq = 1'b1;
    @(posedge clk); @(negedge clk);
    startReq = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R1 async reset busy", busy, 0);
    check("R1 async reset valid", mTvalid, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule